// File: doc/BRIEF.md
# First-Press Quiz Lockout Controller

This block decides which of up to eight contestants pressed a button first. Each contestant owns one active-low push-button input, numbered 1 to 8 from bit 0 upward. Every button is synchronised and debounced. Captured lines stay open while no contestant has been seen. As soon as any captured line shows a press, the capture freezes. Later presses then have no effect until the shared reset is applied.

The frozen capture is priority-encoded into a BCD contestant number. That number is decoded onto an active-low seven-segment pattern, and a level buzzer output is raised in the same cycle. After reset the digit is 0 and the buzzer is silent. A button that is still held while reset is released cannot win until it has been seen released once.

Top module: `quiz_lockout`

## Requirements
- R1: While `rst_n` is low at a clock edge, the capture clears: afterwards `winner_bcd` is 0, `buzzer` is 0 and `seg_n` shows the digit 0.
- R2: A debounced press on `btn_n[k]` (driven low) with no earlier capture makes `winner_bcd` equal k+1.
- R3: `buzzer` is high exactly when `winner_bcd` is non-zero, so it rises in the same cycle the number appears.
- R4: Once a number is captured, presses on any button leave `winner_bcd`, `seg_n` and `buzzer` unchanged.
- R5: If several buttons reach the capture stage in the same clock cycle, the highest-numbered contestant wins.
- R6: A button low for fewer than `DEBOUNCE_CYCLES` consecutive cycles after synchronisation is never captured.
- R7: A button held low across reset release is ignored until it has been seen released for a full debounce window. A later press then wins normally.
- R8: `seg_n` is active-low, with bit 0 = segment a through bit 6 = segment g. For digits 0 to 8 it reads 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78, 0x00.
- R9: The captured number and buzzer stay held for any length of time until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low common reset |
| btn_n | input | NUM_PLAYERS | Contestant buttons, active-low, idle high |
| winner_bcd | output | 4 | BCD number of the first contestant, 0 when none |
| seg_n | output | 7 | Active-low seven-segment pattern, gfedcba |
| buzzer | output | 1 | Level buzzer request, high while a winner is held |

## Verification
The assertions assume that `rst_n` is a clean synchronous level and that the button pins are only sampled through the synchroniser, so that no internal check sees a metastable value. They also assume that the debounce window is at least a few cycles long. The stimulus changes buttons and reset only at falling clock edges and holds every real press well beyond the window. It drives deliberately short pulses only where the debounce rejection itself is under test.

// File: rtl/quiz_lockout_pkg.sv
// Package: shared widths and the seven-segment digit map.
// Assumes digits above 9 are never requested; they blank the display.
package quiz_lockout_pkg;

    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    // Map a BCD digit to an active-low gfedcba segment pattern.
    function automatic seg_t digit_to_seg_n(input bcd_t d);
        seg_t on_hi;
        case (d)
            4'd0:    on_hi = 7'h3F;
            4'd1:    on_hi = 7'h06;
            4'd2:    on_hi = 7'h5B;
            4'd3:    on_hi = 7'h4F;
            4'd4:    on_hi = 7'h66;
            4'd5:    on_hi = 7'h6D;
            4'd6:    on_hi = 7'h7D;
            4'd7:    on_hi = 7'h07;
            4'd8:    on_hi = 7'h7F;
            4'd9:    on_hi = 7'h6F;
            default: on_hi = 7'h00;
        endcase
        return ~on_hi;
    endfunction

endpackage

// File: rtl/quiz_btn_cond.sv
// Module: conditions one contestant button.
// What it does: two-flop synchroniser, debounce filter, and arming.
// The arming stage blocks a press until a release has been seen after reset.
// Assumes: btn_n is asynchronous and active-low; rst_n is synchronous.
module quiz_btn_cond #(
    parameter int DEBOUNCE_CYCLES = 1_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);

    logic             sync1_n, sync2_n;
    logic             db_n;
    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Bring the raw pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_n <= 1'b1;
            sync2_n <= 1'b1;
        end else begin
            sync1_n <= btn_n;
            sync2_n <= sync1_n;
        end
    end

    // Accept a new level only after it persists for the full window;
    // the filter resets to "pressed" so a release must be proven first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_n <= 1'b0;
            cnt  <= '0;
        end else if (sync2_n == db_n) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(DEBOUNCE_CYCLES - 1)) begin
            db_n <= sync2_n;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Arm once a debounced release has been observed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed <= 1'b0;
        else if (db_n)  armed <= 1'b1;
    end

    assign press = armed & ~db_n;

    // R6: the filtered level cannot move while input and filter agree.
    p_db_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync2_n == db_n) |=> $stable(db_n));

    // R7: arming, once gained, is never lost without reset.
    p_arm_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

endmodule

// File: rtl/quiz_capture.sv
// Module: first-press capture register.
// What it does: stays open (follows the presses) while every line is idle.
// It freezes as soon as any line shows a press.
// Assumes: press inputs are synchronous and already debounced.
module quiz_capture #(
    parameter int NUM_PLAYERS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PLAYERS-1:0] press,
    output logic [NUM_PLAYERS-1:0] cap_n,
    output logic                   any_hit
);
    logic open_gate;

    assign open_gate = &cap_n;
    assign any_hit   = ~open_gate;

    // Load while open, hold once any captured line is low.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_n <= '1;
        else if (open_gate) cap_n <= ~press;
    end

    // R4: a frozen capture never changes until reset.
    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> $stable(cap_n));

    // R1: reset leaves every captured line idle.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (&cap_n));

endmodule

// File: rtl/quiz_prio_enc.sv
// Module: priority encoder from captured lines to a contestant number.
// What it does: the highest-numbered low line wins; bit k maps to k+1.
// Assumes: NUM_PLAYERS is at most 9 so the result fits one BCD digit.
module quiz_prio_enc
    import quiz_lockout_pkg::*;
#(
    parameter int NUM_PLAYERS = 8
) (
    input  logic [NUM_PLAYERS-1:0] cap_n,
    output bcd_t                   num
);
    // Scan upward so the highest active line overrides lower ones.
    always_comb begin
        num = '0;
        for (int i = 0; i < NUM_PLAYERS; i++) begin
            if (!cap_n[i]) num = BCD_W'(i + 1);
        end
    end

endmodule

// File: rtl/quiz_seg_drv.sv
// Module: BCD digit to active-low seven-segment pattern.
// Assumes: the digit is in 0..9.
module quiz_seg_drv
    import quiz_lockout_pkg::*;
(
    input  bcd_t digit,
    output seg_t seg_n
);
    // Pure lookup through the shared map.
    always_comb seg_n = digit_to_seg_n(digit);

endmodule

// File: rtl/quiz_lockout.sv
// Module: top of the first-press quiz lockout controller.
// What it does: conditions each button, captures the first press,
// encodes the winner and drives the display digit and the buzzer.
// Assumes: rst_n is a synchronous active-low level; buttons idle high.
module quiz_lockout
    import quiz_lockout_pkg::*;
#(
    parameter int NUM_PLAYERS     = 8,
    parameter int DEBOUNCE_CYCLES = 1_250_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PLAYERS-1:0] btn_n,
    output logic [BCD_W-1:0]       winner_bcd,
    output logic [SEG_W-1:0]       seg_n,
    output logic                   buzzer
);
    logic [NUM_PLAYERS-1:0] press;
    logic [NUM_PLAYERS-1:0] cap_n;
    logic                   any_hit;
    bcd_t                   num;
    seg_t                   seg_w;

    // One conditioner per contestant.
    for (genvar k = 0; k < NUM_PLAYERS; k++) begin : g_btn
        quiz_btn_cond #(
            .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
        ) u_cond (
            .clk  (clk),
            .rst_n(rst_n),
            .btn_n(btn_n[k]),
            .press(press[k])
        );
    end

    quiz_capture #(
        .NUM_PLAYERS(NUM_PLAYERS)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .press  (press),
        .cap_n  (cap_n),
        .any_hit(any_hit)
    );

    quiz_prio_enc #(
        .NUM_PLAYERS(NUM_PLAYERS)
    ) u_enc (
        .cap_n(cap_n),
        .num  (num)
    );

    quiz_seg_drv u_seg (
        .digit(num),
        .seg_n(seg_w)
    );

    assign winner_bcd = num;
    assign seg_n      = seg_w;
    assign buzzer     = any_hit;

    // R3: the buzzer and a non-zero number always agree.
    p_buzz_num_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buzzer == (winner_bcd != '0));

    // R5: the reported contestant's captured line is really active.
    p_win_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (winner_bcd != '0) |-> !cap_n[winner_bcd - 1'b1]);

    // R9: a raised buzzer stays raised until reset.
    p_buzz_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buzzer |=> buzzer);

endmodule

// File: tb/quiz_lockout_bench.sv
module quiz_lockout_bench;
    localparam int N   = 8;
    localparam int DB  = 16;
    localparam int WIN = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] btn_n = '1;
    logic [3:0]   winner_bcd;
    logic [6:0]   seg_n;
    logic         buzzer;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    logic prev_buz = 1'b0;

    always #4 clk = ~clk;

    quiz_lockout #(.NUM_PLAYERS(N), .DEBOUNCE_CYCLES(DB)) u_quiz_lockout (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
        .winner_bcd(winner_bcd), .seg_n(seg_n), .buzzer(buzzer)
    );

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24;
            3: return 7'h30; 4: return 7'h19; 5: return 7'h12;
            6: return 7'h02; 7: return 7'h78; 8: return 7'h00;
            default: return 7'h7F;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
    endtask

    // Driver: announce the expected winner, then press the given buttons.
    task automatic press_expect(input logic [N-1:0] mask, input int winner);
        exp_q.push_back(winner);
        btn_n = ~mask;
        cycles(WIN);
        btn_n = '1;
        cycles(WIN);
    endtask

    // Monitor: on each buzzer rise, pop the expected winner and compare.
    always @(negedge clk) begin
        if (rst_n && buzzer && !prev_buz) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected capture", int'(winner_bcd), 0);
            end else begin
                automatic int e = exp_q.pop_front();
                check(winner_bcd == 4'(e), "R2/R5 winner", int'(winner_bcd), e);
                check(seg_n == exp_seg(e), "R8 segments", int'(seg_n), int'(exp_seg(e)));
                check(buzzer == (winner_bcd != 0), "R3 buzzer with number", int'(buzzer), 1);
            end
        end
        prev_buz = rst_n ? buzzer : 1'b0;
    end

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        cycles(1);
        // R1 reset state and R8 digit 0
        check(winner_bcd == 0, "R1 bcd", int'(winner_bcd), 0);
        check(buzzer == 1'b0, "R1 buzzer", int'(buzzer), 0);
        check(seg_n == exp_seg(0), "R8 reset digit", int'(seg_n), int'(exp_seg(0)));
        cycles(WIN);

        // R2 each contestant alone; R4 a later press is ignored; R9 hold
        for (int k = 0; k < N; k++) begin
            press_expect(N'(1) << k, k + 1);
            btn_n = ~(N'(1) << ((k + 1) % N));
            cycles(WIN);
            check(winner_bcd == 4'(k + 1), "R4 late press ignored", int'(winner_bcd), k + 1);
            check(seg_n == exp_seg(k + 1), "R4 display held", int'(seg_n), int'(exp_seg(k + 1)));
            btn_n = '1;
            cycles(200);
            check(buzzer == 1'b1, "R9 buzzer held", int'(buzzer), 1);
            do_reset();
            cycles(1);
            check(winner_bcd == 0 && !buzzer, "R1 cleared", int'(winner_bcd), 0);
            cycles(WIN);
        end

        // R5 simultaneous presses of contestants 3 and 6
        press_expect(8'b0010_0100, 6);
        do_reset(); cycles(WIN);
        // R5 all buttons at once
        press_expect(8'hFF, 8);
        do_reset(); cycles(WIN);

        // R6 short pulse rejected
        btn_n = ~8'b0000_1000;
        cycles(DB / 2);
        btn_n = '1;
        cycles(WIN);
        check(buzzer == 1'b0, "R6 short pulse", int'(buzzer), 0);
        check(winner_bcd == 0, "R6 number idle", int'(winner_bcd), 0);
        press_expect(8'b0000_1000, 4);
        do_reset(); cycles(WIN);

        // R7 button held across reset
        btn_n = ~8'b0100_0000;
        do_reset();
        cycles(3 * WIN);
        check(buzzer == 1'b0, "R7 stuck button", int'(buzzer), 0);
        check(winner_bcd == 0, "R7 number idle", int'(winner_bcd), 0);
        btn_n = '1;
        cycles(WIN);
        check(buzzer == 1'b0, "R7 after release", int'(buzzer), 0);
        press_expect(8'b0100_0000, 7);

        check(exp_q.size() == 0, "R2 all expected winners seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule